// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block controls how a small processor core leaves its software power-down state. While the core runs, a one-cycle request puts the block into power-down. At that moment it captures two settings: whether pin wake-up is allowed, and which of two active-low pins may wake the core. The two pins are an external interrupt line and a serial receive line. In power-down both oscillator enables are off and the core is held.

To wake the core, the selected pin must stay low for a set number of ticks of an always-on slow timing strobe. A shorter low pulse sends the block back to power-down with no effect. Once the low time has been met, the block:

- enables the RC oscillator and the main oscillator;
- records which pin caused the wake-up;
- keeps the core held through a start-up phase.

The start-up phase ends when the clock-stable input rises or when a start-up timeout, also counted in ticks, expires. The block then issues a one-cycle wake-up interrupt carrying a fixed vector and releases the core. A synchronous hardware reset ends power-down from any state and returns the block to normal running with both oscillators enabled.

Top module: `pdwake_seq`

## Requirements
- R1: After `rst` both oscillator enables are 1, `core_hold` is 0, `wake_irq` is 0, `wake_vec` is 0 and `wake_from_ser` is 0. The block is in its running state.
- R2: A `pd_req` pulse in the running state takes the block to power-down at the next edge. There both oscillator enables are 0 and `core_hold` is 1. `wake_en` and `wake_sel` are captured at that edge, and later changes to them have no effect until the next power-down.
- R3: `pd_req` has no effect in any state other than running. It neither recaptures the settings nor interrupts a wake-up in progress.
- R4: A captured `wake_sel` of 0 selects `ext_int_n` and a value of 1 selects `ser_rx`. A low level on the pin that is not selected has no effect.
- R5: With a captured `wake_en` of 0, no pin activity and no `tick` ends power-down. Only `rst` does.
- R6: Each pin passes through a synchronizer of `SYNC_STAGES` flops. The selected pin must be seen low for `LATCH_TICKS` `tick` strobes before wake-up proceeds. If it returns high earlier, the block goes back to power-down, the low-time count restarts from zero, and no output changes.
- R7: The edge that ends the latch phase sets both oscillator enables to 1, keeps `core_hold` at 1, and loads `wake_from_ser` with the captured selection. After that, the pin returning high does not abort the wake-up.
- R8: In the start-up phase, `clk_ok` sampled high at an edge makes `wake_irq` high after that edge.
- R9: Without `clk_ok`, the start-up phase ends on the `START_TICKS`-th `tick` strobe counted from its first cycle, with `wake_irq` high after that edge.
- R10: `wake_irq` is high for exactly one cycle, and `wake_vec` equals `WAKE_VEC` (default 007Bh) in that cycle and 0 otherwise. `core_hold` is 0 during and after the pulse, and the block is back in the running state.
- R11: `rst` from power-down, latch or start-up returns every output to the R1 values, including clearing `wake_from_ser`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| tick | input | 1 | Always-on slow timing strobe, one cycle wide |
| pd_req | input | 1 | Power-down request strobe |
| wake_en | input | 1 | Pin wake-up allowed (captured on power-down entry) |
| wake_sel | input | 1 | Wake pin select: 0 external interrupt, 1 serial receive |
| ext_int_n | input | 1 | External interrupt wake pin, active low |
| ser_rx | input | 1 | Serial receive wake pin, active low |
| clk_ok | input | 1 | Oscillator supervisor reports a stable clock |
| rc_osc_en | output | 1 | RC oscillator enable |
| main_osc_en | output | 1 | Main oscillator enable |
| core_hold | output | 1 | Holds the core from fetching |
| wake_irq | output | 1 | One-cycle wake-up interrupt request |
| wake_vec | output | VEC_W | Interrupt vector, valid with wake_irq |
| wake_from_ser | output | 1 | Last wake-up came from the serial receive pin |

## Verification
The bench sweeps every combination of captured enable, captured selection and which pin is pulled low, with low times from one tick up to one more than the latch length. This separates "wrong pin" from "disabled" from "too short" from "long enough". Start-up is ended alternately by the clock-stable input and by the tick timeout, and the bench accounts for latch ticks that spill into the start-up count. Directed cases show that:

- two short pulses whose sum reaches the latch length do not wake the core;
- a request during power-down or start-up is ignored;
- reset taken mid start-up clears the recorded source.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_PDOWN = 3'd1,
    ST_LATCH = 3'd2,
    ST_START = 3'd3,
    ST_IRQ   = 3'd4
  } pdw_state_t;

  localparam int unsigned NUM_PINS = 2;
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= RST_VAL;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pdw_tick_cnt.sv
module pdw_tick_cnt #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= '0;
    else if (tick && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pdwake_seq.sv
module pdwake_seq
  import pdw_pkg::*;
#(
  parameter int unsigned LATCH_TICKS = 10,
  parameter int unsigned START_TICKS = 5000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_W       = 16,
  parameter logic [VEC_W-1:0] WAKE_VEC = 16'h007B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pd_req,
  input  logic             wake_en,
  input  logic             wake_sel,
  input  logic             ext_int_n,
  input  logic             ser_rx,
  input  logic             clk_ok,
  output logic             rc_osc_en,
  output logic             main_osc_en,
  output logic             core_hold,
  output logic             wake_irq,
  output logic [VEC_W-1:0] wake_vec,
  output logic             wake_from_ser
);
  pdw_state_t state, nxt;

  logic [NUM_PINS-1:0] pins_raw, pins_s;
  logic en_q, sel_q, pin_lvl;
  logic latch_done, start_done;

  assign pins_raw = {ser_rx, ext_int_n};

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pdw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw[i]),
        .q   (pins_s[i])
      );
    end
  endgenerate

  assign pin_lvl = pins_s[sel_q];

  pdw_tick_cnt #(.LIMIT(LATCH_TICKS)) u_latch_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  ((state == ST_LATCH) && !pin_lvl),
    .tick (tick),
    .done (latch_done)
  );

  pdw_tick_cnt #(.LIMIT(START_TICKS)) u_start_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_START),
    .tick (tick),
    .done (start_done)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:   if (pd_req) nxt = ST_PDOWN;
      ST_PDOWN: if (en_q && !pin_lvl) nxt = ST_LATCH;
      ST_LATCH: begin
        if (pin_lvl)         nxt = ST_PDOWN;
        else if (latch_done) nxt = ST_START;
      end
      ST_START: if (clk_ok || start_done) nxt = ST_IRQ;
      ST_IRQ:   nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (state == ST_RUN && pd_req) begin
      en_q  <= wake_en;
      sel_q <= wake_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_RUN;
      rc_osc_en     <= 1'b1;
      main_osc_en   <= 1'b1;
      core_hold     <= 1'b0;
      wake_irq      <= 1'b0;
      wake_vec      <= '0;
      wake_from_ser <= 1'b0;
    end else begin
      state       <= nxt;
      rc_osc_en   <= (nxt == ST_RUN) || (nxt == ST_START) || (nxt == ST_IRQ);
      main_osc_en <= (nxt != ST_PDOWN) && (nxt != ST_LATCH);
      core_hold   <= (nxt == ST_PDOWN) || (nxt == ST_LATCH) || (nxt == ST_START);
      wake_irq    <= (nxt == ST_IRQ);
      wake_vec    <= (nxt == ST_IRQ) ? WAKE_VEC : '0;
      if (state == ST_LATCH && nxt == ST_START) wake_from_ser <= sel_q;
    end
  end
endmodule

// File: rtl/pdw_chk.sv
module pdw_chk
  import pdw_pkg::*;
#(
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] WAKE_VEC = 16'h007B
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             pd_req,
  input logic             rc_osc_en,
  input logic             main_osc_en,
  input logic             core_hold,
  input logic             wake_irq,
  input logic [VEC_W-1:0] wake_vec,
  input pdw_state_t       state
);
  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rc_osc_en && main_osc_en && !core_hold && !wake_irq)); // R11

  AST_PD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && pd_req) |=> (core_hold && !rc_osc_en && !main_osc_en)); // R2

  AST_LATCH_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && $past(state) == ST_LATCH) |-> $past(tick)); // R6

  AST_STARTUP_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START) |-> (rc_osc_en && main_osc_en && core_hold)); // R7

  AST_IRQ_FROM_STARTUP: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq) |-> ($past(state) == ST_START)); // R8

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    wake_irq |=> !wake_irq); // R10

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> (wake_vec == WAKE_VEC && !core_hold)); // R10

  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wake_irq |-> (wake_vec == '0)); // R10
endmodule

bind pdwake_seq pdw_chk #(.VEC_W(VEC_W), .WAKE_VEC(WAKE_VEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .pd_req      (pd_req),
  .rc_osc_en   (rc_osc_en),
  .main_osc_en (main_osc_en),
  .core_hold   (core_hold),
  .wake_irq    (wake_irq),
  .wake_vec    (wake_vec),
  .state       (state)
);

// File: tb/sim_pdwake_seq.sv
`timescale 1ns/1ps
module sim_pdwake_seq;
  localparam int L = 3;
  localparam int S = 5;
  localparam int VEC = 'h7B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, pd_req = 1'b0, wake_en = 1'b0, wake_sel = 1'b0;
  logic ext_int_n = 1'b1, ser_rx = 1'b1, clk_ok = 1'b0;
  logic rc_osc_en, main_osc_en, core_hold, wake_irq, wake_from_ser;
  logic [15:0] wake_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pdwake_seq #(.LATCH_TICKS(L), .START_TICKS(S)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .pd_req(pd_req), .wake_en(wake_en),
    .wake_sel(wake_sel), .ext_int_n(ext_int_n), .ser_rx(ser_rx), .clk_ok(clk_ok),
    .rc_osc_en(rc_osc_en), .main_osc_en(main_osc_en), .core_hold(core_hold),
    .wake_irq(wake_irq), .wake_vec(wake_vec), .wake_from_ser(wake_from_ser)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic run_state(input string req);
    chk({req, " rc_osc_en"}, rc_osc_en, 1);
    chk({req, " main_osc_en"}, main_osc_en, 1);
    chk({req, " core_hold"}, core_hold, 0);
    chk({req, " wake_irq"}, wake_irq, 0);
    chk({req, " wake_vec"}, wake_vec, 0);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    run_state(req);
    chk({req, " wake_from_ser"}, wake_from_ser, 0);
  endtask

  task automatic enter_pd(input bit en, input bit sel);
    @(negedge clk);
    wake_en = en; wake_sel = sel; pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0; wake_en = ~en; wake_sel = ~sel;
    chk("R2 osc off in power-down", rc_osc_en | main_osc_en, 0);
    chk("R2 hold in power-down", core_hold, 1);
  endtask

  task automatic irq_by_ok(input string req);
    clk_ok = 1'b1;
    @(negedge clk) clk_ok = 1'b0;
    chk({req, " R8 irq on clk_ok"}, wake_irq, 1);
    chk("R10 vector", wake_vec, VEC);
    chk("R10 hold released", core_hold, 0);
    @(negedge clk);
    chk("R10 irq one cycle", wake_irq, 0);
    run_state("R10 back to run");
  endtask

  task automatic irq_by_timeout(input int used);
    ticks(S - 1 - used);
    chk("R9 no irq before timeout", wake_irq, 0);
    chk("R9 hold before timeout", core_hold, 1);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R9 irq at timeout", wake_irq, 1);
    chk("R10 vector", wake_vec, VEC);
    @(negedge clk);
    chk("R10 irq one cycle", wake_irq, 0);
    run_state("R10 back to run");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    run_state("R1 reset state");
    chk("R1 wake_from_ser", wake_from_ser, 0);

    // sweep: enable x select x pulled pin x low time
    for (int en = 0; en < 2; en++)
      for (int sel = 0; sel < 2; sel++)
        for (int pin = 0; pin < 2; pin++)
          for (int n = 1; n <= L + 1; n++) begin
            automatic bit wake = (en == 1) && (pin == sel) && (n >= L);
            automatic int spill = (n > L) ? n - L : 0;
            enter_pd(en[0], sel[0]);
            @(negedge clk);
            if (pin == 0) ext_int_n = 1'b0; else ser_rx = 1'b0;
            repeat (4) @(negedge clk);
            ticks(n);
            chk("R4 R5 R6 osc after low time", rc_osc_en, int'(wake));
            chk("R7 main osc after low time", main_osc_en, int'(wake));
            chk("R7 hold kept", core_hold, 1);
            ext_int_n = 1'b1; ser_rx = 1'b1;
            repeat (4) @(negedge clk);
            chk("R6 R7 state after pin high", rc_osc_en, int'(wake));
            if (wake) begin
              chk("R7 wake source", wake_from_ser, sel);
              if (n % 2 == 1) irq_by_ok("sweep");
              else irq_by_timeout(spill);
            end else begin
              ticks(S + 1);
              chk("R5 R4 stays powered down", rc_osc_en, 0);
              chk("R5 no irq", wake_irq, 0);
              do_reset("R11 reset from power-down");
            end
          end

    // R3: request ignored in power-down and in start-up
    enter_pd(1'b1, 1'b0);
    @(negedge clk);
    wake_en = 1'b0; wake_sel = 1'b1; pd_req = 1'b1;
    @(negedge clk) pd_req = 1'b0;
    ext_int_n = 1'b0;
    repeat (4) @(negedge clk);
    ticks(L);
    ext_int_n = 1'b1;
    chk("R3 settings not recaptured", rc_osc_en, 1);
    chk("R3 source kept", wake_from_ser, 0);
    pd_req = 1'b1;
    @(negedge clk) pd_req = 1'b0;
    chk("R3 request in start-up ignored", core_hold, 1);
    irq_by_ok("R3");

    // R6: two short pulses must not add up
    enter_pd(1'b1, 1'b1);
    ser_rx = 1'b0;
    repeat (4) @(negedge clk);
    ticks(L - 1);
    ser_rx = 1'b1;
    repeat (4) @(negedge clk);
    ser_rx = 1'b0;
    repeat (4) @(negedge clk);
    ticks(L - 1);
    chk("R6 count restarted", rc_osc_en, 0);
    ticks(1);
    chk("R6 full low time wakes", rc_osc_en, 1);
    chk("R7 serial source", wake_from_ser, 1);
    ser_rx = 1'b1;
    repeat (2) @(negedge clk);
    do_reset("R11 reset from start-up");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule